// File: doc/BRIEF.md
# Multiplexed Bus Cycle Sequencer

This block produces the external bus timing for an 8-bit processor that addresses 64K locations. A core hands it one transfer at a time: the kind of transfer (memory or I/O, read or write, opcode fetch or interrupt acknowledge), a 16-bit address and, for writes, a data byte. The sequencer runs a machine cycle of at least three clock states. It drives the upper address byte on its own lane. The lower address byte and the data share a second lane, and an address strobe marks the state in which that lane holds address. Active-low read and write strobes and a three-bit cycle status complete the bus.

A slow memory or peripheral holds READY low to stretch the data phase by whole clocks. Another bus master can ask for the bus with HOLD. The sequencer grants it with HLDA only at a transfer boundary and then floats its outputs. A halt input parks the bus with a dedicated status code. Tri-state is modelled as output-enable signals: each is high when the matching lane is driven.

Top module: `bus_seq_top`

## Requirements
- R1: While `rst` is high, every output enable (`addr_hi_oe`, `ad_oe`, `ctl_oe`, `iom_oe`) is low, `ale` is low, `rd_n` and `wr_n` are high, `hlda`, `busy` and `done` are low.
- R2: A request is accepted at the clock edge where `req_valid` is high in an idle or halted state and `hold` and `hlda` are low. The next clock is the address state. In it `ale` is high, `ad_out` equals address bits 7..0 with `ad_oe` high, and `addr_hi` equals bits 15..8. `ale` is high for exactly one clock per cycle.
- R3: The status `{iom,s1,s0}` follows `req_kind`: 0 memory read gives 010, 1 memory write gives 001, 2 I/O read gives 110, 3 I/O write gives 101, 4 opcode fetch gives 011 and 5 interrupt acknowledge gives 111. Kinds 6 and 7 behave as memory read. The status is valid from the address state and unchanged through the last data state.
- R4: For a read kind, `rd_n` is low from the second state through the third state and `ad_oe` is low. `ad_in` is sampled at the end of the third state. `done` pulses for one clock right after that state with `rdata` holding the sampled byte.
- R5: For a write kind, `wr_n` is low from the second through the third state and `ad_out` carries the write byte with `ad_oe` high. The byte and `ad_oe` stay driven in the clock after `wr_n` returns high, which is the clock in which `done` pulses.
- R6: `ready` is sampled at the end of the second state and of each wait state. Each low sample adds one whole wait clock, so the strobe stays low for 2 + (number of low samples) clocks.
- R7: `rd_n` and `wr_n` are never low together, and neither is low while `ale` is high.
- R8: `hold` is granted only when no transfer is in progress: from idle or halt, or right after the third state. `hlda` rises in the next clock with the bus still driven. All output enables are low from the following clock for as long as `hlda` stays high.
- R9: One clock after `hold` is seen low in the held state, `hlda` is low and the address, control and status lanes are driven again.
- R10: While `halt_in` is high and the block is idle, status bits s1 and s0 are 00 and `iom_oe`, `addr_hi_oe`, `ctl_oe` and `ad_oe` are low. A request or a hold is still taken from halt.
- R11: `busy` is high from the address state through the third state. A `req_valid` seen while busy or while the bus is granted is ignored: no `ale` follows it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal processor clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Transfer request |
| req_kind | input | 3 | Transfer kind code (see R3) |
| req_addr | input | 16 | Transfer address |
| req_wdata | input | 8 | Write byte |
| busy | output | 1 | A machine cycle is running |
| done | output | 1 | One-clock pulse at the end of a cycle |
| rdata | output | 8 | Byte read in the last read cycle |
| ready | input | 1 | Target ready; low inserts wait clocks |
| hold | input | 1 | Bus request from another master |
| halt_in | input | 1 | Park the bus in halt status |
| hlda | output | 1 | Bus grant to the other master |
| addr_hi | output | 8 | Upper address byte |
| addr_hi_oe | output | 1 | Drive enable for `addr_hi` |
| ad_out | output | 8 | Shared low-address/data lane, outgoing |
| ad_oe | output | 1 | Drive enable for `ad_out` |
| ad_in | input | 8 | Shared lane, incoming read data |
| ale | output | 1 | Address strobe for the shared lane |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, active low |
| ctl_oe | output | 1 | Drive enable for `rd_n` and `wr_n` |
| iom | output | 1 | Status: I/O (1) or memory (0) |
| s1 | output | 1 | Status bit 1 |
| s0 | output | 1 | Status bit 0 |
| iom_oe | output | 1 | Drive enable for `iom` |

## Verification
The bench runs each transfer kind with zero to three wait clocks and counts the strobe length. A design that samples READY in the wrong state or adds waits after the third state would show a strobe one clock too long or too short. A hold raised in the middle of a read must wait for the third state. A sequencer that grants early would raise HLDA while a strobe is still low, and one that floats the bus together with HLDA would fail the one-clock release check. The bench also checks that the write byte stays on the lane after WR_n rises, that halt floats IO/M with code 00, and that a request pulsed during a busy cycle produces no extra address strobe.

// File: rtl/bus_seq_pkg.sv
package bus_seq_pkg;

  typedef enum logic [2:0] {
    K_MRD   = 3'd0,
    K_MWR   = 3'd1,
    K_IORD  = 3'd2,
    K_IOWR  = 3'd3,
    K_FETCH = 3'd4,
    K_INTA  = 3'd5
  } kind_e;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_T1,
    PH_T2,
    PH_TW,
    PH_T3,
    PH_HACK,
    PH_HOLD,
    PH_HALT
  } phase_e;

  // {io_not_mem, s1, s0}
  function automatic logic [2:0] status_of(input logic [2:0] k);
    case (k)
      K_MWR:   return 3'b001;
      K_IORD:  return 3'b110;
      K_IOWR:  return 3'b101;
      K_FETCH: return 3'b011;
      K_INTA:  return 3'b111;
      default: return 3'b010;
    endcase
  endfunction

  function automatic logic is_write(input logic [2:0] k);
    return (k == K_MWR) || (k == K_IOWR);
  endfunction

endpackage

// File: rtl/bus_seq_ctrl.sv
module bus_seq_ctrl
  import bus_seq_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_valid,
  input  logic [2:0]    req_kind,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  input  logic          ready,
  input  logic          hold,
  input  logic          halt_in,
  input  logic [DW-1:0] ad_in,
  output phase_e        phase,
  output logic [2:0]    lat_kind,
  output logic [AW-1:0] lat_addr,
  output logic [DW-1:0] lat_wdata,
  output logic          wr_tail,
  output logic          done,
  output logic [DW-1:0] rdata
);

  phase_e phase_nx;
  logic   accept;

  assign accept = ((phase == PH_IDLE) || (phase == PH_HALT)) && !hold && req_valid;

  always_comb begin
    phase_nx = phase;
    case (phase)
      PH_IDLE: begin
        if (hold)           phase_nx = PH_HACK;
        else if (req_valid) phase_nx = PH_T1;
        else if (halt_in)   phase_nx = PH_HALT;
      end
      PH_HALT: begin
        if (hold)           phase_nx = PH_HACK;
        else if (req_valid) phase_nx = PH_T1;
        else if (!halt_in)  phase_nx = PH_IDLE;
      end
      PH_T1:   phase_nx = PH_T2;
      PH_T2,
      PH_TW:   phase_nx = ready ? PH_T3 : PH_TW;
      PH_T3:   phase_nx = hold ? PH_HACK : PH_IDLE;
      PH_HACK: phase_nx = PH_HOLD;
      PH_HOLD: phase_nx = hold ? PH_HOLD : PH_IDLE;
      default: phase_nx = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase     <= PH_IDLE;
      lat_kind  <= K_MRD;
      lat_addr  <= '0;
      lat_wdata <= '0;
      wr_tail   <= 1'b0;
      done      <= 1'b0;
      rdata     <= '0;
    end else begin
      phase   <= phase_nx;
      done    <= (phase == PH_T3);
      wr_tail <= (phase == PH_T3) && is_write(lat_kind);
      if (accept) begin
        lat_kind  <= req_kind;
        lat_addr  <= req_addr;
        lat_wdata <= req_wdata;
      end
      if ((phase == PH_T3) && !is_write(lat_kind))
        rdata <= ad_in;
    end
  end

endmodule

// File: rtl/bus_seq_drive.sv
module bus_seq_drive
  import bus_seq_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 8,
  localparam int HW = AW - DW
) (
  input  logic          rst,
  input  phase_e        phase,
  input  logic [2:0]    lat_kind,
  input  logic [AW-1:0] lat_addr,
  input  logic [DW-1:0] lat_wdata,
  input  logic          wr_tail,
  output logic [HW-1:0] addr_hi,
  output logic          addr_hi_oe,
  output logic [DW-1:0] ad_out,
  output logic          ad_oe,
  output logic          ale,
  output logic          rd_n,
  output logic          wr_n,
  output logic          ctl_oe,
  output logic          iom,
  output logic          s1,
  output logic          s0,
  output logic          iom_oe,
  output logic          hlda,
  output logic          busy
);

  logic       data_ph;
  logic       wr_kind;
  logic [2:0] st;

  assign data_ph = (phase == PH_T2) || (phase == PH_TW) || (phase == PH_T3);
  assign wr_kind = is_write(lat_kind);
  assign st      = status_of(lat_kind);

  always_comb begin
    addr_hi    = lat_addr[AW-1:DW];
    ad_out     = (phase == PH_T1) ? lat_addr[DW-1:0] : lat_wdata;
    ale        = (phase == PH_T1);
    rd_n       = !(data_ph && !wr_kind);
    wr_n       = !(data_ph && wr_kind);
    {iom, s1, s0} = st;
    hlda       = (phase == PH_HACK) || (phase == PH_HOLD);
    busy       = (phase == PH_T1) || data_ph;
    addr_hi_oe = 1'b1;
    ctl_oe     = 1'b1;
    iom_oe     = 1'b1;
    ad_oe      = (phase == PH_T1) || (data_ph && wr_kind) ||
                 (wr_tail && ((phase == PH_IDLE) || (phase == PH_HACK) || (phase == PH_HALT)));
    if (phase == PH_HALT) begin
      s1         = 1'b0;
      s0         = 1'b0;
      addr_hi_oe = 1'b0;
      ctl_oe     = 1'b0;
      iom_oe     = 1'b0;
    end
    if (phase == PH_HOLD || rst) begin
      addr_hi_oe = 1'b0;
      ad_oe      = 1'b0;
      ctl_oe     = 1'b0;
      iom_oe     = 1'b0;
    end
    if (rst) begin
      ale  = 1'b0;
      rd_n = 1'b1;
      wr_n = 1'b1;
      hlda = 1'b0;
      busy = 1'b0;
    end
  end

endmodule

// File: rtl/bus_seq_top.sv
module bus_seq_top
  import bus_seq_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 8,
  localparam int HW = AW - DW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_valid,
  input  logic [2:0]    req_kind,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  output logic          busy,
  output logic          done,
  output logic [DW-1:0] rdata,
  input  logic          ready,
  input  logic          hold,
  input  logic          halt_in,
  output logic          hlda,
  output logic [HW-1:0] addr_hi,
  output logic          addr_hi_oe,
  output logic [DW-1:0] ad_out,
  output logic          ad_oe,
  input  logic [DW-1:0] ad_in,
  output logic          ale,
  output logic          rd_n,
  output logic          wr_n,
  output logic          ctl_oe,
  output logic          iom,
  output logic          s1,
  output logic          s0,
  output logic          iom_oe
);

  phase_e        phase;
  logic [2:0]    lat_kind;
  logic [AW-1:0] lat_addr;
  logic [DW-1:0] lat_wdata;
  logic          wr_tail;
  logic          done_r;

  bus_seq_ctrl #(.AW(AW), .DW(DW)) ctrl_i (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_kind  (req_kind),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .ready     (ready),
    .hold      (hold),
    .halt_in   (halt_in),
    .ad_in     (ad_in),
    .phase     (phase),
    .lat_kind  (lat_kind),
    .lat_addr  (lat_addr),
    .lat_wdata (lat_wdata),
    .wr_tail   (wr_tail),
    .done      (done_r),
    .rdata     (rdata)
  );

  assign done = done_r && !rst;

  bus_seq_drive #(.AW(AW), .DW(DW)) drive_i (
    .rst        (rst),
    .phase      (phase),
    .lat_kind   (lat_kind),
    .lat_addr   (lat_addr),
    .lat_wdata  (lat_wdata),
    .wr_tail    (wr_tail),
    .addr_hi    (addr_hi),
    .addr_hi_oe (addr_hi_oe),
    .ad_out     (ad_out),
    .ad_oe      (ad_oe),
    .ale        (ale),
    .rd_n       (rd_n),
    .wr_n       (wr_n),
    .ctl_oe     (ctl_oe),
    .iom        (iom),
    .s1         (s1),
    .s0         (s0),
    .iom_oe     (iom_oe),
    .hlda       (hlda),
    .busy       (busy)
  );

endmodule

// File: rtl/bus_seq_chk.sv
module bus_seq_chk (
  input logic clk,
  input logic rst,
  input logic ale,
  input logic rd_n,
  input logic wr_n,
  input logic iom,
  input logic s1,
  input logic s0,
  input logic iom_oe,
  input logic addr_hi_oe,
  input logic ad_oe,
  input logic ctl_oe,
  input logic hlda,
  input logic done
);

  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(!rd_n && !wr_n)); // R7

  AST_ALE_NO_STROBE: assert property (@(posedge clk) disable iff (rst)
    ale |-> (rd_n && wr_n)); // R7

  AST_ALE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    ale |=> !ale); // R2

  AST_STATUS_STABLE: assert property (@(posedge clk) disable iff (rst)
    (!rd_n || !wr_n) |-> $stable({iom, s1, s0})); // R3

  AST_DONE_AFTER_STROBE: assert property (@(posedge clk) disable iff (rst)
    done |-> $past(!rd_n || !wr_n)); // R4

  AST_HELD_FLOAT: assert property (@(posedge clk) disable iff (rst)
    (hlda && $past(hlda)) |-> !(addr_hi_oe || ad_oe || ctl_oe || iom_oe)); // R8

  AST_GRANT_IDLE: assert property (@(posedge clk) disable iff (rst)
    $rose(hlda) |-> (rd_n && wr_n && !ale)); // R8

  AST_HALT_CODE: assert property (@(posedge clk) disable iff (rst)
    (!iom_oe && !hlda) |-> (!s1 && !s0)); // R10

endmodule

bind bus_seq_top bus_seq_chk chk_i (
  .clk        (clk),
  .rst        (rst),
  .ale        (ale),
  .rd_n       (rd_n),
  .wr_n       (wr_n),
  .iom        (iom),
  .s1         (s1),
  .s0         (s0),
  .iom_oe     (iom_oe),
  .addr_hi_oe (addr_hi_oe),
  .ad_oe      (ad_oe),
  .ctl_oe     (ctl_oe),
  .hlda       (hlda),
  .done       (done)
);

// File: tb/bus_seq_tb.sv
module bus_seq_top_tb_top;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic [2:0]  req_kind = 3'd0;
  logic [15:0] req_addr = 16'h0;
  logic [7:0]  req_wdata = 8'h0;
  logic        ready = 1'b1;
  logic        hold = 1'b0;
  logic        halt_in = 1'b0;
  logic        busy, done, hlda, addr_hi_oe, ad_oe, ale, rd_n, wr_n, ctl_oe;
  logic        iom, s1, s0, iom_oe;
  logic [7:0]  rdata, addr_hi, ad_out, ad_in;
  logic [15:0] cur_addr = 16'h0;

  int n_checks = 0;
  int n_errors = 0;

  typedef struct {
    logic        wr;
    logic [15:0] a;
    logic [7:0]  d;
    logic [2:0]  st;
  } exp_t;

  exp_t sb_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [7:0] mem_fn(input logic [15:0] a);
    return a[7:0] ^ a[15:8] ^ 8'h5A;
  endfunction

  function automatic logic [2:0] exp_status(input logic [2:0] k);
    case (k)
      3'd1: return 3'b001;
      3'd2: return 3'b110;
      3'd3: return 3'b101;
      3'd4: return 3'b011;
      3'd5: return 3'b111;
      default: return 3'b010;
    endcase
  endfunction

  assign ad_in = mem_fn(cur_addr);

  bus_seq_top dut_i (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_kind(req_kind),
    .req_addr(req_addr), .req_wdata(req_wdata), .busy(busy), .done(done),
    .rdata(rdata), .ready(ready), .hold(hold), .halt_in(halt_in), .hlda(hlda),
    .addr_hi(addr_hi), .addr_hi_oe(addr_hi_oe), .ad_out(ad_out), .ad_oe(ad_oe),
    .ad_in(ad_in), .ale(ale), .rd_n(rd_n), .wr_n(wr_n), .ctl_oe(ctl_oe),
    .iom(iom), .s1(s1), .s0(s0), .iom_oe(iom_oe)
  );

  task automatic check(input logic ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Monitor: scoreboard consumer
  always @(negedge clk) begin
    if (!rst && ale) begin
      cur_addr = {addr_hi, ad_out};
      if (sb_q.size() == 0) begin
        check(1'b0, "R11 unexpected ale", 32'd1, 32'd0);
      end else begin
        check({addr_hi, ad_out} == sb_q[0].a && ad_oe && addr_hi_oe,
              "R2 address lanes", {addr_hi, ad_out}, sb_q[0].a);
        check({iom, s1, s0} == sb_q[0].st, "R3 status at ale",
              {iom, s1, s0}, sb_q[0].st);
      end
    end
    if (!rst && done) begin
      if (sb_q.size() == 0) begin
        check(1'b0, "R4 unexpected done", 32'd1, 32'd0);
      end else begin
        exp_t e;
        e = sb_q.pop_front();
        if (e.wr)
          check(ad_oe && ad_out == e.d && wr_n, "R5 write byte held after wr_n rise",
                {ad_oe, ad_out}, {1'b1, e.d});
        else
          check(rdata == e.d, "R4 read data", rdata, e.d);
      end
    end
  end

  task automatic run_cycle(input logic [2:0] kind, input logic [15:0] addr,
                           input logic [7:0] wd, input int nwait,
                           input logic hold_mid, input logic spur);
    exp_t e;
    int   strobes;
    logic wr;
    wr     = (kind == 3'd1) || (kind == 3'd3);
    e.wr   = wr;
    e.a    = addr;
    e.d    = wr ? wd : mem_fn(addr);
    e.st   = exp_status(kind);
    sb_q.push_back(e);
    @(negedge clk);
    req_valid = 1'b1; req_kind = kind; req_addr = addr; req_wdata = wd;
    @(negedge clk);
    req_valid = 1'b0;
    check(ale && busy, "R2 R11 address state", {ale, busy}, 2'b11);
    strobes = 0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (!rd_n || !wr_n) begin
        strobes++;
        check(wr ? rd_n : wr_n, "R7 one strobe only", {rd_n, wr_n}, wr ? 2'b10 : 2'b01);
        check({iom, s1, s0} == e.st && busy && !ale, "R3 status held in data state",
              {iom, s1, s0}, e.st);
        if (!wr) check(!ad_oe, "R4 lane released for read", ad_oe, 0);
        ready = (strobes > nwait);
        if (hold_mid && strobes == 1) hold = 1'b1;
        if (spur && strobes == 1) begin
          req_valid = 1'b1; req_addr = 16'hDEAD; req_kind = 3'd0;
        end
        if (spur && strobes == 2) req_valid = 1'b0;
        if (hold_mid) check(!hlda, "R8 no grant mid-transfer", hlda, 0);
      end else begin
        break;
      end
    end
    req_valid = 1'b0;
    ready = 1'b1;
    check(strobes == nwait + 2, "R6 strobe length", strobes, nwait + 2);
    check(done && !busy, "R4 done pulse", {done, busy}, 2'b10);
    if (hold_mid) begin
      check(hlda && addr_hi_oe && ctl_oe, "R8 grant with bus still driven",
            {hlda, addr_hi_oe, ctl_oe}, 3'b111);
      @(negedge clk);
      check(hlda && !addr_hi_oe && !ad_oe && !ctl_oe && !iom_oe, "R8 bus floated",
            {hlda, addr_hi_oe, ad_oe, ctl_oe, iom_oe}, 5'b10000);
      hold = 1'b0;
      @(negedge clk);
      check(!hlda && addr_hi_oe && ctl_oe && iom_oe, "R9 bus resumed",
            {hlda, addr_hi_oe, ctl_oe, iom_oe}, 4'b0111);
    end
    if (spur) begin
      for (int j = 0; j < 3; j++) begin
        @(negedge clk);
        check(!ale && !busy, "R11 ignored request", {ale, busy}, 2'b00);
      end
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_errors++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check(!addr_hi_oe && !ad_oe && !ctl_oe && !iom_oe, "R1 enables low in reset",
          {addr_hi_oe, ad_oe, ctl_oe, iom_oe}, 4'b0);
    check(!ale && rd_n && wr_n && !hlda && !busy && !done, "R1 controls idle in reset",
          {ale, rd_n, wr_n, hlda, busy, done}, 6'b011000);
    rst = 1'b0;
    @(negedge clk);

    run_cycle(3'd0, 16'h1234, 8'h00, 0, 1'b0, 1'b0);
    run_cycle(3'd1, 16'hABCD, 8'h3C, 0, 1'b0, 1'b0);
    run_cycle(3'd2, 16'h0040, 8'h00, 2, 1'b0, 1'b0);
    run_cycle(3'd3, 16'h0081, 8'hC5, 1, 1'b0, 1'b0);
    run_cycle(3'd4, 16'hFFFF, 8'h00, 0, 1'b0, 1'b0);
    run_cycle(3'd5, 16'h0038, 8'h00, 3, 1'b0, 1'b0);
    run_cycle(3'd0, 16'h8001, 8'h00, 1, 1'b1, 1'b0);
    run_cycle(3'd1, 16'h2200, 8'h99, 0, 1'b0, 1'b1);

    // R8 R9 R11 hold from idle, request during grant ignored
    @(negedge clk);
    hold = 1'b1;
    @(negedge clk);
    check(hlda && addr_hi_oe, "R8 idle grant", {hlda, addr_hi_oe}, 2'b11);
    req_valid = 1'b1; req_addr = 16'hBEEF;
    @(negedge clk);
    check(hlda && !addr_hi_oe && !ctl_oe && !ale, "R8 R11 held and ignored",
          {hlda, addr_hi_oe, ctl_oe, ale}, 4'b1000);
    hold = 1'b0; req_valid = 1'b0;
    @(negedge clk);
    check(!hlda && addr_hi_oe && !ale, "R9 release", {hlda, addr_hi_oe, ale}, 3'b010);

    // R10 halt
    halt_in = 1'b1;
    @(negedge clk);
    check(!s1 && !s0 && !iom_oe && !addr_hi_oe && !ctl_oe && !ad_oe && !busy,
          "R10 halt parks bus", {s1, s0, iom_oe, addr_hi_oe, ctl_oe, ad_oe}, 6'b0);
    run_cycle(3'd2, 16'h0155, 8'h00, 0, 1'b0, 1'b0);
    @(negedge clk);
    check(!iom_oe && !s1 && !s0, "R10 halt re-entered", {iom_oe, s1, s0}, 3'b0);
    halt_in = 1'b0;
    @(negedge clk);
    check(iom_oe && addr_hi_oe, "R10 halt exit", {iom_oe, addr_hi_oe}, 2'b11);

    check(sb_q.size() == 0, "R4 scoreboard drained", sb_q.size(), 0);
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

endmodule